// File: doc/BRIEF.md
# Product-Term OR Chain with Expander Borrowing

This block forms the sum-of-products outputs of a chain of eight logic cells. Each cell brings five product terms, already formed by an AND array elsewhere, and by default ORs them into its own output. A cell can instead lend its five terms upward to a neighbour. A cell can also borrow up to three such sets of five from the cells directly below it, so that as many as twenty terms feed one OR.

The configuration is set per cell. A lend bit hands the cell's terms upward. A two-bit borrow count (0 to 3) says how many sets the cell takes from below. The block reports three things for each cell: its OR result, the number of expander sets that reached it, and an error bit. The error bit is set when the configuration cannot be honoured. Borrowing only moves upward, and it stays inside the chain. The lowest cell can only lend and the highest can only borrow.

Top module: `pterm_borrow_chain`

## Requirements
- R1: A cell with its lend bit clear, a borrow count of zero and no error drives its sum bit high exactly when any of its own five terms is high. Cell c owns term bits [5c+4:5c] of `pt_i`.
- R2: A cell with borrow count k (1..3), held in `borrow_i[2c+1:2c]`, ORs its own terms with the terms of cells c-1 down to c-k. It reports k on `sets_o[2c+1:2c]`.
- R3: A cell whose lend bit is set drives its sum bit low and reports zero sets, whatever its own terms are.
- R4: A borrow of k sets is legal only when every cell from c-1 down to c-k has its lend bit set. Otherwise the cell's error bit is set.
- R5: Cell 0 has no lower neighbour. Any nonzero borrow count on cell 0 sets its error bit.
- R6: Cell 7 has no upper neighbour. Setting its lend bit sets its error bit.
- R7: A cell that both lends and has a nonzero borrow count sets its error bit.
- R8: A cell with its error bit set drives its sum bit low and reports zero sets.
- R9: Terms of a lending cell that lies outside a borrower's window do not reach any output. For example, with a borrow of 1 at cell c, the terms of cell c-2 have no effect even if cell c-2 lends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pt_i | input | 40 | Product terms, five per cell, cell c at bits [5c+4:5c] |
| lend_i | input | 8 | Per-cell lend enable; bit c for cell c |
| borrow_i | input | 16 | Per-cell borrow count 0..3, cell c at bits [2c+1:2c] |
| sum_o | output | 8 | Per-cell OR result |
| sets_o | output | 16 | Per-cell count of expander sets chained in, same layout as borrow_i |
| cfg_err_o | output | 8 | Per-cell configuration error flag |

## Verification
Some rules are checked whenever the inputs are known. A lending cell stays silent. An error forces the sum low and the set count to zero. A non-lending cell with a live term of its own drives its output high. The end cells reject their forbidden modes. Only the bench scenarios can show that the right neighbours' terms, and no others, enter a borrower's OR, and that a window of one, two or three sets is honoured exactly. The bench covers every legal borrowing window in every cell, term by term, as well as random mixes of legal and illegal configurations.

// File: rtl/pterm_borrow_chain.sv
module pterm_borrow_chain #(
  parameter int CELLS    = 8,
  parameter int PTS      = 5,
  parameter int MAX_SETS = 3,
  localparam int BW      = $clog2(MAX_SETS + 1)
) (
  input  logic [CELLS*PTS-1:0] pt_i,
  input  logic [CELLS-1:0]     lend_i,
  input  logic [CELLS*BW-1:0]  borrow_i,
  output logic [CELLS-1:0]     sum_o,
  output logic [CELLS*BW-1:0]  sets_o,
  output logic [CELLS-1:0]     cfg_err_o
);

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    logic [BW-1:0] req;
    logic          own_or;
    logic          lent_or;
    logic          bad;

    assign req    = borrow_i[c*BW +: BW];
    assign own_or = |pt_i[c*PTS +: PTS];

    always_comb begin
      bad     = lend_i[c] && (req != '0 || c == CELLS - 1);
      lent_or = 1'b0;
      for (int k = 1; k <= MAX_SETS; k++) begin
        if (k <= int'(req)) begin
          if (c - k < 0) begin
            bad = 1'b1;
          end else begin
            if (!lend_i[(c - k < 0) ? 0 : c - k]) bad = 1'b1;
            lent_or = lent_or | (|pt_i[((c - k < 0) ? 0 : c - k)*PTS +: PTS]);
          end
        end
      end
    end

    assign cfg_err_o[c]         = bad;
    assign sum_o[c]             = !bad && !lend_i[c] && (own_or || lent_or);
    assign sets_o[c*BW +: BW]   = (bad || lend_i[c]) ? '0 : req;

    always_comb begin
      if (!$isunknown({pt_i, lend_i, borrow_i})) begin
        a_r3_lender_quiet: assert (!lend_i[c] || (!sum_o[c] && sets_o[c*BW +: BW] == '0));
        a_r8_error_forces_low: assert (!cfg_err_o[c] || (!sum_o[c] && sets_o[c*BW +: BW] == '0));
        a_r1_own_term_reaches: assert (cfg_err_o[c] || lend_i[c] || !(|pt_i[c*PTS +: PTS]) || sum_o[c]);
      end
    end

    if (c == 0) begin : g_bottom
      always_comb begin
        if (!$isunknown({lend_i, borrow_i}))
          a_r5_bottom_no_borrow: assert (borrow_i[BW-1:0] == '0 || cfg_err_o[0]);
      end
    end

    if (c == CELLS - 1) begin : g_top
      always_comb begin
        if (!$isunknown({lend_i, borrow_i}))
          a_r6_top_no_lend: assert (!lend_i[CELLS-1] || cfg_err_o[CELLS-1]);
      end
    end
  end

endmodule

// File: tb/tb_pterm_borrow_chain.sv
module tb_pterm_borrow_chain;
  localparam int N = 8, P = 5, NT = 8;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic [N*P-1:0] pt;
  logic [N-1:0]   lend;
  logic [2*N-1:0] bor;
  logic [N-1:0]   sum, err;
  logic [2*N-1:0] sets;
  int checks = 0, fails = 0;
  bit done = 0;

  pterm_borrow_chain dut (.pt_i(pt), .lend_i(lend), .borrow_i(bor),
                          .sum_o(sum), .sets_o(sets), .cfg_err_o(err));

  localparam logic [N-1:0]   T_LEND [NT] = '{8'h00, 8'h01, 8'h07, 8'h00, 8'h00, 8'h80, 8'h03, 8'h60};
  localparam logic [2*N-1:0] T_BOR  [NT] = '{16'h0000, 16'h0004, 16'h00C0, 16'h0010,
                                             16'h0002, 16'h0000, 16'h0004, 16'h8000};
  localparam logic [N*P-1:0] T_PT   [NT] = '{40'h12_3456_789A, 40'h00_0000_001F, 40'h00_0000_4210,
                                             40'hFF_FFFF_FFFF, 40'h00_0000_0020, 40'h80_0000_0000,
                                             40'h00_0000_03FF, 40'h00_6000_0000};
  localparam logic [N-1:0]   T_ERR  [NT] = '{8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h80, 8'h02, 8'h00};

  function automatic logic [4*N-1:0] model(logic [N*P-1:0] t, logic [N-1:0] l, logic [2*N-1:0] b);
    logic [N-1:0] s = '0, e = '0;
    logic [2*N-1:0] d = '0;
    for (int c = 0; c < N; c++) begin
      int k = int'(b[2*c +: 2]);
      logic hit = |t[c*P +: P];
      logic bad = 1'b0;
      if (l[c] && (k != 0 || c == N - 1)) bad = 1'b1;
      for (int j = 1; j <= k; j++) begin
        if (c - j < 0) bad = 1'b1;
        else begin
          if (!l[c-j]) bad = 1'b1;
          hit = hit | (|t[(c-j)*P +: P]);
        end
      end
      e[c] = bad;
      if (!bad && !l[c]) begin
        s[c] = hit;
        d[2*c +: 2] = b[2*c +: 2];
      end
    end
    return {e, d, s};
  endfunction

  task automatic apply_check(input string tag);
    logic [4*N-1:0] exp_v;
    @(posedge clk);
    exp_v = model(pt, lend, bor);
    @(negedge clk);
    checks++;
    if ({err, sets, sum} !== exp_v) begin
      fails++;
      $display("FAIL %s: got err=%h sets=%h sum=%h expected err=%h sets=%h sum=%h",
               tag, err, sets, sum, exp_v[4*N-1:3*N], exp_v[3*N-1:N], exp_v[N-1:0]);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    pt = '0; lend = '0; bor = '0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    apply_check("R1 idle zero");

    for (int i = 0; i < NT; i++) begin
      pt = T_PT[i]; lend = T_LEND[i]; bor = T_BOR[i];
      apply_check("R2 R4 R5 R6 R7 table");
      checks++;
      if (err !== T_ERR[i]) begin
        fails++;
        $display("FAIL R4/R5/R6/R7 table %0d: got err=%h expected %h", i, err, T_ERR[i]);
      end
    end

    for (int c = 0; c < N; c++)
      for (int k = 0; k <= 3 && k <= c; k++)
        for (int b = 0; b < (k + 1) * P; b++) begin
          pt = '0; lend = '0; bor = '0;
          for (int j = 1; j <= k; j++) lend[c-j] = 1'b1;
          bor[2*c +: 2] = 2'(k);
          pt[(c - k) * P + b] = 1'b1;
          apply_check("R2 legal window single term");
        end

    pt = '0; pt[4*P +: P] = 5'h1F; pt[3*P] = 1'b0;
    lend = 8'h38; bor = '0; bor[2*6 +: 2] = 2'd1;
    apply_check("R9 lender outside window");
    checks++;
    if (sum[6] !== 1'b0) begin
      fails++;
      $display("FAIL R9: got sum6=%b expected 0", sum[6]);
    end

    pt = {N*P{1'b1}}; lend = 8'h7F; bor = '0;
    apply_check("R3 all lenders");
    checks++;
    if (sum !== 8'h80) begin
      fails++;
      $display("FAIL R3: got sum=%h expected 80", sum);
    end

    for (int i = 0; i < 3000; i++) begin
      pt = {$urandom, $urandom};
      lend = 8'($urandom);
      bor = 16'($urandom);
      apply_check("R4 R7 R8 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule